// File: doc/BRIEF.md
# Configuration Port Unlock Sequencer

This block is a byte-wide I/O slave that sits behind a two-byte window. Offset 0 is a shared key/index port and offset 1 is a data port. At reset the configuration space is sealed: index and data traffic has no effect. Two consecutive writes of a key byte to offset 0 open the space. While open, offset 0 picks a register index and offset 1 reads or writes that register. Writing an exit byte to offset 0 seals the space again.

The register space is split in two. Indices below 0x30 are global and shared. Indices from 0x30 upward are banked: each logical device has its own copy, and the global register at index 0x07 selects which bank is visible. One bank is tied to a downstream watchdog. Its registers and its activate bit (bit 0 of its register 0x30) are driven out as ports at all times, whichever bank is currently selected.

Top module: `cfgport_unlock`

## Requirements
- R1: After reset the block is locked, the index is 0x00, the logical device number (global index 0x07) is 0x00, every register holds 0x00, and `wdt_active` is 0.
- R2: The block unlocks only when the key byte (default 0x87) is written to offset 0 (`port_sel`=0) on two consecutive writes. A single key write leaves it locked.
- R3: Any other write between the two key writes restarts the key sequence. This includes a write of another value to offset 0 and any write to offset 1.
- R4: While locked, writes to either offset change no register and leave the index unchanged. Reads at offset 1 return 0xFF.
- R5: While unlocked, a write to offset 0 (other than the exit byte) sets the index. A read at offset 0 returns the index. Reads and writes at offset 1 reach the indexed register. `rdata` is combinational and valid in the cycle `rd_en` is high; it is 0x00 when `rd_en` is low.
- R6: Writing the exit byte (default 0xAA) to offset 0 while unlocked locks the block and leaves the index unchanged.
- R7: Registers at indices 0x00 to 0x2F are global: a value written with one logical device selected reads back unchanged with another selected.
- R8: Registers at indices 0x30 to 0x30+BANK_REGS-1 are banked per logical device. A write with device A selected does not alter device B's copy.
- R9: `wdt_active` equals bit 0 of register 0x30 of logical device WDT_LDEV (default 8). `wdt_regs[8*i+:8]` equals that device's register 0x30+i. Both hold regardless of the selected device, and both change only on an unlocked offset-1 write.
- R10: An index at or above 0x30+BANK_REGS, or a selected device number at or above NUM_LDEV, reads 0xFF and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_sel | input | 1 | Window offset: 0 key/index port, 1 data port |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| unlocked | output | 1 | Configuration space open |
| wdt_active | output | 1 | Activate bit of the watchdog bank |
| wdt_regs | output | 8*BANK_REGS | Watchdog bank registers, byte i is index 0x30+i |

## Verification
The bench builds the block with NUM_LDEV=9, BANK_REGS=4 and WDT_LDEV=8, so the watchdog bank is the last device that exists. With these values, device number 9 is the first out-of-range bank, and index 0x34 is the first unimplemented banked index. Both edges of R10 can therefore be reached with a few writes. The small bank also keeps `wdt_regs` at 32 bits, so the bench compares the whole watchdog bank in one check after each banked write.

// File: rtl/cfgport_unlock.sv
module cfgport_unlock #(
  parameter logic [7:0] KEY_BYTE  = 8'h87,
  parameter logic [7:0] EXIT_BYTE = 8'hAA,
  parameter int NUM_LDEV  = 10,
  parameter int BANK_REGS = 16,
  parameter int WDT_LDEV  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   port_sel,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  output logic                   unlocked,
  output logic                   wdt_active,
  output logic [BANK_REGS*8-1:0] wdt_regs
);
  localparam int         GLOB_REGS = 48;
  localparam logic [7:0] BANK_BASE = 8'h30;
  localparam int         LDN_IDX   = 7;
  localparam int         NB        = NUM_LDEV * BANK_REGS;
  localparam int         SW        = (NB > 1) ? $clog2(NB) : 1;
  localparam int         WBASE     = WDT_LDEV * BANK_REGS;

  logic          key_armed, unl_q;
  logic [7:0]    idx_q;
  logic [7:0]    glob_q [GLOB_REGS];
  logic [7:0]    bank_q [NB];
  logic [7:0]    ldn, boff;
  logic          is_glob, is_bank;
  logic [SW-1:0] slot;
  logic [5:0]    gslot;

  assign ldn     = glob_q[LDN_IDX];
  assign boff    = idx_q - BANK_BASE;
  assign is_glob = idx_q < BANK_BASE;
  assign is_bank = !is_glob && (int'(boff) < BANK_REGS) && (int'(ldn) < NUM_LDEV);
  assign gslot   = idx_q[5:0];
  assign slot    = is_bank ? SW'(int'(ldn) * BANK_REGS + int'(boff)) : '0;
  assign unlocked = unl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_armed <= 1'b0;
      unl_q     <= 1'b0;
      idx_q     <= 8'h00;
    end else if (wr_en) begin
      if (!unl_q) begin
        if (!port_sel && wdata == KEY_BYTE) begin
          unl_q     <= key_armed;
          key_armed <= !key_armed;
        end else begin
          key_armed <= 1'b0;
        end
      end else if (!port_sel) begin
        if (wdata == EXIT_BYTE) unl_q <= 1'b0;
        else                    idx_q <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < GLOB_REGS; i++) glob_q[i] <= 8'h00;
    end else if (wr_en && port_sel && unl_q && is_glob) begin
      glob_q[gslot] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) bank_q[i] <= 8'h00;
    end else if (wr_en && port_sel && unl_q && is_bank) begin
      bank_q[slot] <= wdata;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      if (!unl_q)       rdata = 8'hFF;
      else if (!port_sel) rdata = idx_q;
      else if (is_glob) rdata = glob_q[gslot];
      else if (is_bank) rdata = bank_q[slot];
      else              rdata = 8'hFF;
    end
  end

  for (genvar g = 0; g < BANK_REGS; g++) begin : g_wdt
    assign wdt_regs[g*8 +: 8] = bank_q[WBASE + g];
  end
  assign wdt_active = bank_q[WBASE][0];
endmodule

module cfgport_unlock_chk #(
  parameter int         WW   = 128,
  parameter logic [7:0] KEY  = 8'h87,
  parameter logic [7:0] EXIT = 8'hAA
) (
  input logic          clk,
  input logic          rst_n,
  input logic          port_sel,
  input logic          wr_en,
  input logic          rd_en,
  input logic [7:0]    wdata,
  input logic [7:0]    rdata,
  input logic          unlocked,
  input logic          wdt_active,
  input logic [WW-1:0] wdt_regs
);
  assert_unlock_by_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(wr_en && !port_sel && wdata == KEY));

  assert_locked_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && rd_en && port_sel) |-> rdata == 8'hFF);

  assert_locked_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && wr_en) |=> ($stable(wdt_regs) && $stable(wdt_active)));

  assert_exit_locks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && wr_en && !port_sel && wdata == EXIT) |=> !unlocked);

  assert_wdt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(unlocked && wr_en && port_sel) |=> $stable(wdt_regs));

  assert_idle_rdata_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 8'h00);
endmodule

bind cfgport_unlock cfgport_unlock_chk #(
  .WW(BANK_REGS*8), .KEY(KEY_BYTE), .EXIT(EXIT_BYTE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .unlocked(unlocked), .wdt_active(wdt_active),
  .wdt_regs(wdt_regs)
);

// File: tb/cfgport_unlock_bench.sv
module cfgport_unlock_bench;
  localparam int CLK_P = 10;
  localparam int BR    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          port_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]    wdata = 8'h00;
  logic [7:0]    rdata;
  logic          unlocked, wdt_active;
  logic [BR*8-1:0] wdt_regs;
  int n_chk = 0, n_bad = 0;

  cfgport_unlock #(.NUM_LDEV(9), .BANK_REGS(BR), .WDT_LDEV(8)) u_cfgport_unlock (
    .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .unlocked(unlocked), .wdt_active(wdt_active),
    .wdt_regs(wdt_regs));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); port_sel = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); port_sel = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] v);
    wr(1'b0, idx); wr(1'b1, v);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] v);
    wr(1'b0, idx); rd(1'b1, v);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 locked", unlocked, 0);
    check("R1 wdt_active", wdt_active, 0);
    check("R1 wdt_regs", wdt_regs, 0);
    rd(1'b1, d); check("R1 data read locked", d, 8'hFF);
  endtask

  task automatic t_locked_ignore;
    logic [7:0] d;
    wr(1'b1, 8'h55);
    wr(1'b0, 8'h30);
    check("R4 still locked", unlocked, 0);
    rd(1'b1, d); check("R4 locked data read", d, 8'hFF);
    rd(1'b0, d); check("R4 locked index read", d, 8'hFF);
  endtask

  task automatic t_key_sequence;
    wr(1'b0, 8'h87);
    check("R2 single key", unlocked, 0);
    wr(1'b0, 8'h12);
    wr(1'b0, 8'h87);
    check("R3 broken by value", unlocked, 0);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h87);
    check("R3 broken by data write", unlocked, 0);
    wr(1'b0, 8'h87);
    check("R2 double key", unlocked, 1);
  endtask

  task automatic t_reset_state_open;
    logic [7:0] d;
    rd(1'b0, d); check("R1 R4 index zero", d, 8'h00);
    reg_rd(8'h00, d); check("R4 locked write ignored", d, 8'h00);
    reg_rd(8'h07, d); check("R1 ldn zero", d, 8'h00);
  endtask

  task automatic t_index_data;
    logic [7:0] d;
    wr(1'b0, 8'h21);
    rd(1'b0, d); check("R5 index readback", d, 8'h21);
    wr(1'b1, 8'hC3);
    rd(1'b1, d); check("R5 data readback", d, 8'hC3);
    reg_wr(8'h2F, 8'h9E);
    reg_rd(8'h2F, d); check("R5 top global", d, 8'h9E);
  endtask

  task automatic t_global_shared;
    logic [7:0] d;
    reg_wr(8'h07, 8'h08);
    reg_wr(8'h20, 8'h5A);
    reg_wr(8'h07, 8'h03);
    reg_rd(8'h20, d); check("R7 global shared", d, 8'h5A);
  endtask

  task automatic t_banked;
    logic [7:0] d;
    reg_wr(8'h07, 8'h03);
    reg_wr(8'h31, 8'h33);
    reg_wr(8'h07, 8'h08);
    reg_rd(8'h31, d); check("R8 bank 8 untouched", d, 8'h00);
    reg_wr(8'h31, 8'h88);
    reg_wr(8'h30, 8'h01);
    reg_wr(8'h33, 8'hE7);
    reg_wr(8'h07, 8'h03);
    reg_rd(8'h31, d); check("R8 bank 3 kept", d, 8'h33);
  endtask

  task automatic t_wdt_outputs;
    check("R9 wdt_active", wdt_active, 1);
    check("R9 wdt_regs", wdt_regs, 32'hE7008801);
    reg_wr(8'h30, 8'h00);
    check("R9 other bank no effect", wdt_active, 1);
    check("R9 wdt_regs stable", wdt_regs, 32'hE7008801);
  endtask

  task automatic t_out_of_range;
    logic [7:0] d;
    reg_wr(8'h34, 8'h77);
    reg_rd(8'h34, d); check("R10 unimplemented index", d, 8'hFF);
    reg_wr(8'h07, 8'h09);
    reg_wr(8'h30, 8'h5C);
    reg_rd(8'h30, d); check("R10 ldn out of range", d, 8'hFF);
    check("R10 wdt bank untouched", wdt_regs, 32'hE7008801);
  endtask

  task automatic t_exit;
    logic [7:0] d;
    reg_wr(8'h07, 8'h08);
    wr(1'b0, 8'h30);
    wr(1'b0, 8'hAA);
    check("R6 exit locks", unlocked, 0);
    wr(1'b1, 8'h00);
    check("R6 write after exit ignored", wdt_active, 1);
    rd(1'b1, d); check("R6 read after exit", d, 8'hFF);
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
    rd(1'b0, d); check("R6 index kept over exit", d, 8'h30);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_locked_ignore();
    t_key_sequence();
    t_reset_state_open();
    t_index_data();
    t_global_shared();
    t_banked();
    t_wdt_outputs();
    t_out_of_range();
    t_exit();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule